// File: doc/BRIEF.md
# Per-CPU Interrupt Presenter

This block sits between a set of interrupt source controllers and one processor. It holds a single pending interrupt and decides whether that processor should be interrupted. Each pending interrupt has a source number and a priority. The processor has a current priority. A numerically smaller priority value is more favoured.

Source controllers offer deliveries, each with a source number, a priority and the identity of the controller. A delivery can be refused, which sends a refusal back to the requester. It can be taken as the new pending interrupt. When a more favoured delivery displaces an older pending interrupt, the older one is bounced back to the controller that owns it. Software also has an inter-processor request priority. When that priority is set below the processor priority, the presenter shows a fixed source number, and this competes with external interrupts.

The processor works the block through one-cycle register operations:
- setting the processor priority,
- setting the inter-processor request priority,
- accept,
- end-of-interrupt,
- poll.

End-of-interrupt is passed on to the source side. When nothing is pending, a resend request is raised so that sources offer their refused interrupts again.

Top module: `irq_presenter`

## Requirements
- R1: After reset the interrupt line is low, the interrupt word (processor priority in bits 31:24, pending source number in bits 23:0) reads 0x00000000, the inter-processor request priority reads 0xFF, and the pending priority is 0xFF. A source number of 0 means nothing is pending.
- R2: A delivery is taken when two conditions hold. Its priority must be below the processor priority. Nothing must be pending, or the pending interrupt must have a numerically larger priority. When a delivery is taken, the source number is stored, the interrupt line is high on the next cycle, and a poll shows the new source.
- R3: A delivery is refused when either of two conditions holds. Its priority is greater than or equal to the processor priority. Or something is pending at an equal or more favoured priority. A refused delivery causes a one-cycle `nack_valid_o` pulse carrying its source number, and the pending state is unchanged.
- R4: A taken delivery that displaces a pending interrupt owned by a source controller causes a one-cycle bounce pulse. The pulse carries the displaced source number and its owner identity.
- R5: Accept (op code 2) returns the whole interrupt word on `rd_data_o` with `rd_valid_o` on the next cycle. It lowers the line and loads the processor priority with the pending priority. It clears the source number and sets the pending priority to 0xFF.
- R6: Set inter-processor priority (op code 1) stores bits 7:0 of the data. If the value is below the processor priority and nothing is pending at an equal or more favoured priority, source number 2 becomes pending at that priority and the line rises. Any owned pending interrupt is bounced. Otherwise the pending state is unchanged.
- R7: Set processor priority (op code 0) to a lower value withdraws a pending interrupt whose priority is greater than or equal to the new value. The withdrawal clears it, sets the pending priority to 0xFF and lowers the line. The withdrawn interrupt is bounced only if a source controller owns it. A pending inter-processor interrupt (source 2) has no owner, so its withdrawal produces no bounce.
- R8: Set processor priority to an equal or higher value while nothing is pending issues a one-cycle `resend_o` pulse. A resend also presents source 2 if the inter-processor priority is below the new processor priority.
- R9: End-of-interrupt (op code 3) loads the processor priority from data bits 31:24. It pulses `eoi_valid_o` with the source number from data bits 23:0. If nothing is pending afterwards, it issues a resend as in R8.
- R10: Poll (op code 4) returns the interrupt word on `rd_data_o` and the inter-processor priority on `rd_ipi_o`, and changes no state.
- R11: When an operation and a delivery arrive in the same cycle, the operation is applied first. The delivery is then judged against the resulting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Processor operation strobe |
| op_code_i | input | 3 | 0 set priority, 1 set inter-processor priority, 2 accept, 3 end-of-interrupt, 4 poll |
| op_data_i | input | 32 | Operation data |
| dlv_valid_i | input | 1 | Delivery offer from a source controller |
| dlv_src_i | input | 24 | Offered source number (non-zero) |
| dlv_prio_i | input | 8 | Offered priority |
| dlv_own_i | input | 4 | Identity of the offering controller |
| irq_o | output | 1 | Interrupt line to the processor |
| rd_valid_o | output | 1 | Read data valid for accept or poll |
| rd_data_o | output | 32 | Interrupt word read back |
| rd_ipi_o | output | 8 | Inter-processor priority read back by poll |
| bounce_valid_o | output | 1 | Displaced or withdrawn interrupt returned to its owner |
| bounce_src_o | output | 24 | Bounced source number |
| bounce_own_o | output | 4 | Owner of the bounced interrupt |
| nack_valid_o | output | 1 | Offered delivery refused |
| nack_src_o | output | 24 | Refused source number |
| eoi_valid_o | output | 1 | End-of-interrupt forwarded to the source side |
| eoi_src_o | output | 24 | Source number of the end-of-interrupt |
| resend_o | output | 1 | Request to the source side to offer refused interrupts again |

## Verification
The assertions check properties that hold on every cycle:
- A delivery at priority 0xFF is always refused.
- A bounce happens only while the line was high.
- Accept or poll always produces read data one cycle later.
- An accept with no delivery in the same cycle leaves the line low.
- An end-of-interrupt forwards the written source number.

The orderings that need a known history can only be shown by the bench's scenarios. These are:
- preemption of an owned interrupt against an inter-processor one,
- withdrawal with and without an owner,
- a resend that re-presents source 2,
- priority update by end-of-interrupt,
- an operation racing a delivery in the same cycle.

// File: rtl/ipr_pkg.sv
package ipr_pkg;
  parameter int SRC_W  = 24;
  parameter int PRIO_W = 8;
  parameter int OWN_W  = 4;
  localparam int XIRR_W = PRIO_W + SRC_W;
  localparam logic [SRC_W-1:0]  IPI_SRC  = SRC_W'(2);
  localparam logic [PRIO_W-1:0] PRIO_OFF = '1;

  typedef enum logic [2:0] {
    OP_SET_PRIO = 3'd0,
    OP_SET_IPI  = 3'd1,
    OP_ACCEPT   = 3'd2,
    OP_EOI      = 3'd3,
    OP_POLL     = 3'd4
  } op_e;

  typedef struct packed {
    logic [PRIO_W-1:0] cppr;
    logic [SRC_W-1:0]  xisr;
    logic [PRIO_W-1:0] pp;
    logic [PRIO_W-1:0] ipi;
    logic              own_v;
    logic [OWN_W-1:0]  own_id;
  } pst_t;
endpackage

// File: rtl/ipr_op_unit.sv
module ipr_op_unit
  import ipr_pkg::*;
(
  input  pst_t              st_i,
  input  logic              op_valid_i,
  input  op_e               op_i,
  input  logic [XIRR_W-1:0] data_i,
  output pst_t              st_o,
  output logic              bounce_v_o,
  output logic [SRC_W-1:0]  bounce_src_o,
  output logic [OWN_W-1:0]  bounce_own_o,
  output logic              eoi_v_o,
  output logic [SRC_W-1:0]  eoi_src_o,
  output logic              resend_o,
  output logic              rd_v_o,
  output logic [XIRR_W-1:0] rd_o
);
  pst_t              s;
  logic [PRIO_W-1:0] v, old_cppr;
  logic              do_ipi, do_resend;

  assign v = data_i[PRIO_W-1:0];

  always_comb begin
    s            = st_i;
    old_cppr     = st_i.cppr;
    bounce_v_o   = 1'b0;
    bounce_src_o = '0;
    bounce_own_o = '0;
    eoi_v_o      = 1'b0;
    eoi_src_o    = '0;
    rd_v_o       = 1'b0;
    rd_o         = {st_i.cppr, st_i.xisr};
    do_ipi       = 1'b0;
    do_resend    = 1'b0;
    if (op_valid_i) begin
      case (op_i)
        OP_SET_PRIO: begin
          s.cppr = v;
          if (v < old_cppr) begin
            if (s.xisr != '0 && v <= s.pp) begin
              bounce_v_o   = s.own_v;
              bounce_src_o = s.xisr;
              bounce_own_o = s.own_id;
              s.xisr  = '0;
              s.pp    = PRIO_OFF;
              s.own_v = 1'b0;
            end
          end else if (s.xisr == '0) begin
            do_resend = 1'b1;
          end
        end
        OP_SET_IPI: begin
          s.ipi = v;
          if (v < s.cppr) do_ipi = 1'b1;
        end
        OP_ACCEPT: begin
          rd_v_o  = 1'b1;
          s.cppr  = s.pp;
          s.xisr  = '0;
          s.pp    = PRIO_OFF;
          s.own_v = 1'b0;
        end
        OP_EOI: begin
          s.cppr    = data_i[XIRR_W-1:SRC_W];
          eoi_v_o   = 1'b1;
          eoi_src_o = data_i[SRC_W-1:0];
          if (s.xisr == '0) do_resend = 1'b1;
        end
        OP_POLL: rd_v_o = 1'b1;
        default: ;
      endcase
    end
    if (do_resend && s.ipi < s.cppr) do_ipi = 1'b1;
    // IPI check: present source 2 unless something at least as favoured waits
    if (do_ipi && !(s.xisr != '0 && s.pp <= s.ipi)) begin
      if (s.xisr != '0 && s.own_v) begin
        bounce_v_o   = 1'b1;
        bounce_src_o = s.xisr;
        bounce_own_o = s.own_id;
      end
      s.xisr  = IPI_SRC;
      s.pp    = s.ipi;
      s.own_v = 1'b0;
    end
    st_o     = s;
    resend_o = do_resend;
  end
endmodule

// File: rtl/ipr_dlv_unit.sv
module ipr_dlv_unit
  import ipr_pkg::*;
(
  input  pst_t              st_i,
  input  logic              dlv_valid_i,
  input  logic [SRC_W-1:0]  dlv_src_i,
  input  logic [PRIO_W-1:0] dlv_prio_i,
  input  logic [OWN_W-1:0]  dlv_own_i,
  input  logic              bounce_v_i,
  input  logic [SRC_W-1:0]  bounce_src_i,
  input  logic [OWN_W-1:0]  bounce_own_i,
  output pst_t              st_o,
  output logic              bounce_v_o,
  output logic [SRC_W-1:0]  bounce_src_o,
  output logic [OWN_W-1:0]  bounce_own_o,
  output logic              nack_v_o,
  output logic [SRC_W-1:0]  nack_src_o
);
  logic busy, refuse;

  assign busy   = st_i.xisr != '0;
  assign refuse = (dlv_prio_i >= st_i.cppr) || (busy && st_i.pp <= dlv_prio_i);

  always_comb begin
    st_o         = st_i;
    bounce_v_o   = bounce_v_i;
    bounce_src_o = bounce_src_i;
    bounce_own_o = bounce_own_i;
    nack_v_o     = 1'b0;
    nack_src_o   = dlv_src_i;
    if (dlv_valid_i) begin
      if (refuse) begin
        nack_v_o = 1'b1;
      end else begin
        // an owned pending entry here implies the op stage bounced nothing
        if (busy && st_i.own_v) begin
          bounce_v_o   = 1'b1;
          bounce_src_o = st_i.xisr;
          bounce_own_o = st_i.own_id;
        end
        st_o.xisr   = dlv_src_i;
        st_o.pp     = dlv_prio_i;
        st_o.own_v  = 1'b1;
        st_o.own_id = dlv_own_i;
      end
    end
  end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import ipr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [2:0]        op_code_i,
  input  logic [XIRR_W-1:0] op_data_i,
  input  logic              dlv_valid_i,
  input  logic [SRC_W-1:0]  dlv_src_i,
  input  logic [PRIO_W-1:0] dlv_prio_i,
  input  logic [OWN_W-1:0]  dlv_own_i,
  output logic              irq_o,
  output logic              rd_valid_o,
  output logic [XIRR_W-1:0] rd_data_o,
  output logic [PRIO_W-1:0] rd_ipi_o,
  output logic              bounce_valid_o,
  output logic [SRC_W-1:0]  bounce_src_o,
  output logic [OWN_W-1:0]  bounce_own_o,
  output logic              nack_valid_o,
  output logic [SRC_W-1:0]  nack_src_o,
  output logic              eoi_valid_o,
  output logic [SRC_W-1:0]  eoi_src_o,
  output logic              resend_o
);
  pst_t              st_q, st_op, st_d;
  logic              ob_v, db_v, nk_v, eo_v, rs_v, rd_v;
  logic [SRC_W-1:0]  ob_src, db_src, nk_src, eo_src;
  logic [OWN_W-1:0]  ob_own, db_own;
  logic [XIRR_W-1:0] rd_w;

  ipr_op_unit u_op (
    .st_i(st_q), .op_valid_i(op_valid_i), .op_i(op_e'(op_code_i)), .data_i(op_data_i),
    .st_o(st_op), .bounce_v_o(ob_v), .bounce_src_o(ob_src), .bounce_own_o(ob_own),
    .eoi_v_o(eo_v), .eoi_src_o(eo_src), .resend_o(rs_v), .rd_v_o(rd_v), .rd_o(rd_w)
  );

  ipr_dlv_unit u_dlv (
    .st_i(st_op), .dlv_valid_i(dlv_valid_i), .dlv_src_i(dlv_src_i),
    .dlv_prio_i(dlv_prio_i), .dlv_own_i(dlv_own_i),
    .bounce_v_i(ob_v), .bounce_src_i(ob_src), .bounce_own_i(ob_own),
    .st_o(st_d), .bounce_v_o(db_v), .bounce_src_o(db_src), .bounce_own_o(db_own),
    .nack_v_o(nk_v), .nack_src_o(nk_src)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= '{cppr: '0, xisr: '0, pp: PRIO_OFF, ipi: PRIO_OFF,
                          own_v: 1'b0, own_id: '0};
      rd_valid_o     <= 1'b0;
      rd_data_o      <= '0;
      rd_ipi_o       <= PRIO_OFF;
      bounce_valid_o <= 1'b0;
      bounce_src_o   <= '0;
      bounce_own_o   <= '0;
      nack_valid_o   <= 1'b0;
      nack_src_o     <= '0;
      eoi_valid_o    <= 1'b0;
      eoi_src_o      <= '0;
      resend_o       <= 1'b0;
    end else begin
      st_q           <= st_d;
      rd_valid_o     <= rd_v;
      if (rd_v) begin
        rd_data_o <= rd_w;
        rd_ipi_o  <= st_q.ipi;
      end
      bounce_valid_o <= db_v;
      bounce_src_o   <= db_src;
      bounce_own_o   <= db_own;
      nack_valid_o   <= nk_v;
      nack_src_o     <= nk_src;
      eoi_valid_o    <= eo_v;
      eoi_src_o      <= eo_src;
      resend_o       <= rs_v;
    end
  end

  assign irq_o = st_q.xisr != '0;
endmodule

// File: rtl/irq_presenter_chk.sv
module irq_presenter_chk
  import ipr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [2:0]        op_code_i,
  input logic [XIRR_W-1:0] op_data_i,
  input logic              dlv_valid_i,
  input logic [PRIO_W-1:0] dlv_prio_i,
  input logic              irq_o,
  input logic              rd_valid_o,
  input logic              bounce_valid_o,
  input logic              nack_valid_o,
  input logic              eoi_valid_o,
  input logic [SRC_W-1:0]  eoi_src_o
);
  p_off_prio_refused_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_valid_i && dlv_prio_i == PRIO_OFF) |=> nack_valid_o);

  p_bounce_needs_line_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bounce_valid_o |-> $past(irq_o));

  p_accept_lowers_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == OP_ACCEPT && !dlv_valid_i) |=> !irq_o);

  p_read_returns_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op_code_i == OP_ACCEPT || op_code_i == OP_POLL)) |=> rd_valid_o);

  p_eoi_forward_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == OP_EOI) |=>
      (eoi_valid_o && eoi_src_o == $past(op_data_i[SRC_W-1:0])));
endmodule

bind irq_presenter irq_presenter_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
  .op_data_i(op_data_i), .dlv_valid_i(dlv_valid_i), .dlv_prio_i(dlv_prio_i),
  .irq_o(irq_o), .rd_valid_o(rd_valid_o), .bounce_valid_o(bounce_valid_o),
  .nack_valid_o(nack_valid_o), .eoi_valid_o(eoi_valid_o), .eoi_src_o(eoi_src_o)
);

// File: tb/irq_presenter_tb.sv
module irq_presenter_tb;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        op_valid_i = 1'b0, dlv_valid_i = 1'b0;
  logic [2:0]  op_code_i = '0;
  logic [31:0] op_data_i = '0;
  logic [23:0] dlv_src_i = '0;
  logic [7:0]  dlv_prio_i = '0;
  logic [3:0]  dlv_own_i = '0;
  logic        irq_o, rd_valid_o, bounce_valid_o, nack_valid_o, eoi_valid_o, resend_o;
  logic [31:0] rd_data_o;
  logic [7:0]  rd_ipi_o;
  logic [23:0] bounce_src_o, nack_src_o, eoi_src_o;
  logic [3:0]  bounce_own_o;
  int checks = 0, errors = 0;

  localparam logic [2:0] SETP = 3'd0, SETI = 3'd1, ACC = 3'd2, EOI = 3'd3, POLL = 3'd4;

  always #5 clk_i = ~clk_i;

  irq_presenter u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // drive at negedge, results sampled at the following negedge
  task automatic cyc(logic ov, logic [2:0] oc, logic [31:0] od,
                     logic dv, logic [23:0] ds, logic [7:0] dp, logic [3:0] dw);
    op_valid_i = ov; op_code_i = oc; op_data_i = od;
    dlv_valid_i = dv; dlv_src_i = ds; dlv_prio_i = dp; dlv_own_i = dw;
    @(posedge clk_i); @(negedge clk_i);
    op_valid_i = 1'b0; dlv_valid_i = 1'b0;
  endtask

  task automatic op(logic [2:0] c, logic [31:0] d);
    cyc(1'b1, c, d, 1'b0, '0, '0, '0);
  endtask

  task automatic dlv(logic [23:0] s, logic [7:0] p, logic [3:0] w);
    cyc(1'b0, '0, '0, 1'b1, s, p, w);
  endtask

  task automatic poll_chk(string req, logic [31:0] exp_w, logic [7:0] exp_i);
    op(POLL, '0);
    chk(req, rd_valid_o, 1'b1);
    chk(req, rd_data_o, exp_w);
    chk(req, rd_ipi_o, exp_i);
  endtask

  task automatic t_reset;
    chk("R1 irq", irq_o, 1'b0);
    poll_chk("R1 poll", 32'h0000_0000, 8'hFF);
    op(ACC, '0);   // cppr takes pending priority 0xFF
    chk("R1 accept", rd_data_o, 32'h0000_0000);
    poll_chk("R1 pp", 32'hFF00_0000, 8'hFF);
  endtask

  task automatic t_deliver_refuse;
    op(SETP, 32'hFF);
    chk("R8 resend", resend_o, 1'b1);
    dlv(24'h123, 8'h05, 4'd1);
    chk("R2 irq", irq_o, 1'b1);
    chk("R2 nack", nack_valid_o, 1'b0);
    poll_chk("R2 R10 poll", 32'hFF00_0123, 8'hFF);
    poll_chk("R10 again", 32'hFF00_0123, 8'hFF);
    dlv(24'h200, 8'h05, 4'd2);
    chk("R3 nack", nack_valid_o, 1'b1);
    chk("R3 src", nack_src_o, 24'h200);
    chk("R3 bounce", bounce_valid_o, 1'b0);
    poll_chk("R3 unchanged", 32'hFF00_0123, 8'hFF);
  endtask

  task automatic t_preempt_accept_eoi;
    dlv(24'h300, 8'h03, 4'd2);
    chk("R4 bounce", bounce_valid_o, 1'b1);
    chk("R4 src", bounce_src_o, 24'h123);
    chk("R4 own", bounce_own_o, 4'd1);
    op(ACC, '0);
    chk("R5 rd", rd_data_o, 32'hFF00_0300);
    chk("R5 irq", irq_o, 1'b0);
    poll_chk("R5 cppr", 32'h0300_0000, 8'hFF);
    op(EOI, 32'hFF00_0300);
    chk("R9 eoi", eoi_valid_o, 1'b1);
    chk("R9 src", eoi_src_o, 24'h300);
    chk("R9 resend", resend_o, 1'b1);
    poll_chk("R9 cppr", 32'hFF00_0000, 8'hFF);
  endtask

  task automatic t_ipi;
    dlv(24'h400, 8'h06, 4'd3);
    op(SETI, 32'h04);
    chk("R6 bounce", bounce_valid_o, 1'b1);
    chk("R6 src", bounce_src_o, 24'h400);
    chk("R6 own", bounce_own_o, 4'd3);
    poll_chk("R6 ipi", 32'hFF00_0002, 8'h04);
    op(SETI, 32'h07);
    chk("R6 no bounce", bounce_valid_o, 1'b0);
    poll_chk("R6 kept", 32'hFF00_0002, 8'h07);
  endtask

  task automatic t_withdraw;
    op(SETP, 32'h02);
    chk("R7 ipi no bounce", bounce_valid_o, 1'b0);
    chk("R7 irq", irq_o, 1'b0);
    poll_chk("R7 word", 32'h0200_0000, 8'h07);
    dlv(24'h500, 8'h01, 4'd1);
    chk("R7 taken", irq_o, 1'b1);
    op(SETP, 32'h01);
    chk("R7 bounce", bounce_valid_o, 1'b1);
    chk("R7 src", bounce_src_o, 24'h500);
    chk("R7 irq low", irq_o, 1'b0);
  endtask

  task automatic t_resend_ipi;
    op(SETP, 32'hFF);
    chk("R8 resend", resend_o, 1'b1);
    chk("R8 irq", irq_o, 1'b1);
    poll_chk("R8 ipi shown", 32'hFF00_0002, 8'h07);
    op(ACC, '0);
    chk("R5 ipi rd", rd_data_o, 32'hFF00_0002);
    op(EOI, 32'hFF00_0002);
    chk("R9 resend ipi", irq_o, 1'b1);
    op(SETI, 32'hFF);
    op(ACC, '0);
    op(SETP, 32'hFF);
    chk("R8 no ipi", irq_o, 1'b0);
  endtask

  task automatic t_same_cycle;
    cyc(1'b1, SETP, 32'h03, 1'b1, 24'h600, 8'h05, 4'd2);
    chk("R11 nack", nack_valid_o, 1'b1);
    chk("R11 no bounce", bounce_valid_o, 1'b0);
    chk("R11 irq", irq_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_deliver_refuse;
    t_preempt_accept_eoi;
    t_ipi;
    t_withdraw;
    t_resend_ipi;
    t_same_cycle;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule